// File: doc/BRIEF.md
# Multi-Mode Receive Sample FIFO

This block sits between a serial receiver and a 32-bit internal bus. The receiver side offers one sample per cycle. Each sample carries up to 20 data bits, a width tag that marks a full 20-bit slot or a narrower one, and a flag that marks the first slot of a frame. The bus side pops one sample per read. One cycle later it gets the sample left-justified in a 32-bit word, laid out according to a 2-bit mode input. The modes are plain UART, 8-bit codec, 16-bit codec and a slot mode for AC'97-style framed audio.

The receiver has an enable input and a synchronous receiver reset. The reset empties the queue, clears the sticky overrun bit and drops the interrupt request. Incoming samples are then refused until the enable has been taken low and raised again. Stored samples remain readable while the receiver is disabled. The interrupt request is high whenever the receiver is enabled and data is waiting.

Top module: `rx_sample_fifo`

## Requirements
- R1: With mode 00 (UART) or 01 (8-bit codec), a popped sample returns `push_data[7:0]` on `rd_data[31:24]`, and bits 23..0 read as zero.
- R2: With mode 10 (16-bit codec), a popped sample returns `push_data[15:0]` on `rd_data[31:16]`, and bits 15..0 read as zero.
- R3: With mode 11 (slot mode) and the stored width tag set (20-bit slot), `rd_data[31:12]` carries the 20 data bits, `rd_data[11]` carries the stored first-slot flag, and bits 10..0 are zero.
- R4: With mode 11 and the width tag clear (16-bit slot), `rd_data[31:16]` carries `push_data[15:0]`, bits 15..12 and 10..0 are zero, and bit 11 carries the first-slot flag.
- R5: Outside mode 11, `rd_data[11]` reads zero whatever the stored first-slot flag is.
- R6: Samples leave in arrival order. A pop on a non-empty queue gives `rd_valid` high with the data in the following cycle. A pop on an empty queue gives no `rd_valid` and changes nothing.
- R7: `empty` is high with no entries stored and `full` is high with 16 (DEPTH) entries stored.
- R8: A push while full, with no pop in the same cycle, is dropped and sets the sticky `overrun` bit. A push and a pop in the same cycle while full are both carried out, and `overrun` does not change.
- R9: Pushes are ignored while `rx_enable` is low. Pops still return stored data while it is low.
- R10: A `rx_reset` cycle empties the queue and clears `overrun`. It takes priority over a pop in the same cycle, so no `rd_valid` follows.
- R11: After `rx_reset`, pushes are refused until `rx_enable` has been seen low and is high again.
- R12: `irq` equals `rx_enable` AND NOT `empty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rx_reset | input | 1 | Synchronous receiver reset: flush, clear status, disarm |
| rx_enable | input | 1 | Receiver enable |
| mode | input | 2 | 00 UART, 01 8-bit codec, 10 16-bit codec, 11 slot mode |
| push_valid | input | 1 | Sample offered by the receiver this cycle |
| push_data | input | 20 | Sample bits, right-justified |
| push_wide | input | 1 | 1 = 20-bit slot, 0 = 16-bit slot (slot mode) |
| push_first | input | 1 | Sample is the first slot of a frame |
| pop | input | 1 | Bus read of one sample |
| rd_valid | output | 1 | `rd_data` holds a freshly popped sample |
| rd_data | output | 32 | Left-justified sample word |
| empty | output | 1 | No samples stored |
| full | output | 1 | DEPTH samples stored |
| overrun | output | 1 | Sticky: a sample was dropped because the queue was full |
| irq | output | 1 | Interrupt request |

## Verification
The functions that share a cycle are a receiver push and a bus pop while the queue is full. The bench fills all 16 entries, clears the overrun bit first, and then raises `push_valid` and `pop` on the same edge. It requires `full` to stay high, `overrun` to stay low and the oldest sample to come out, and it later sees the new sample arrive last in the drain. A second collision is `rx_reset` and `pop` together. There the bench requires that no `rd_valid` follows and that the queue reads empty.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int SLOT_W = 20;
  localparam int BUS_W  = 32;

  typedef enum logic [1:0] {
    MODE_UART    = 2'b00,
    MODE_CODEC8  = 2'b01,
    MODE_CODEC16 = 2'b10,
    MODE_SLOT    = 2'b11
  } mode_e;

  typedef struct packed {
    logic              first;
    logic              wide;
    logic [SLOT_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int W     = 22,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_reset,
  input  logic          rx_enable,
  input  logic          push_valid,
  input  logic          pop,
  output logic          do_push,
  output logic          do_pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          rd_valid
);
  logic [AW:0] count;
  logic        armed;
  logic        offer;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign offer   = push_valid && rx_enable && armed && !rx_reset;
  assign do_pop  = pop && !empty && !rx_reset;
  assign do_push = offer && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overrun  <= 1'b0;
      rd_valid <= 1'b0;
      armed    <= 1'b1;
    end else if (rx_reset) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overrun  <= 1'b0;
      rd_valid <= 1'b0;
      armed    <= 1'b0;
    end else begin
      rd_valid <= do_pop;
      if (!rx_enable) armed <= 1'b1;
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (offer && full && !do_pop) overrun <= 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    rx_reset |=> (empty && !overrun && !rd_valid));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && !rx_reset) |=> overrun);

  // R9
  disabled_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_enable && !pop && !rx_reset) |=> $stable(count));

  // R6
  valid_after_pop_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(pop));
endmodule

// File: rtl/rxf_align.sv
module rxf_align
  import rxf_pkg::*;
(
  input  mode_e              mode,
  input  entry_t             ent,
  output logic [BUS_W-1:0]   word
);
  always_comb begin
    case (mode)
      MODE_SLOT: begin
        if (ent.wide) word = {ent.data, ent.first, 11'b0};
        else          word = {ent.data[15:0], 4'b0, ent.first, 11'b0};
      end
      MODE_CODEC16: word = {ent.data[15:0], 16'b0};
      default:      word = {ent.data[7:0], 24'b0};
    endcase
  end
endmodule

// File: rtl/rx_sample_fifo.sv
module rx_sample_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_reset,
  input  logic        rx_enable,
  input  logic [1:0]  mode,
  input  logic        push_valid,
  input  logic [19:0] push_data,
  input  logic        push_wide,
  input  logic        push_first,
  input  logic        pop,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        empty,
  output logic        full,
  output logic        overrun,
  output logic        irq
);
  logic          do_push, do_pop;
  logic [AW-1:0] wptr, rptr;
  entry_t        wr_ent, rd_ent;
  mode_e         mode_q;

  assign wr_ent = '{first: push_first, wide: push_wide, data: push_data};

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .rx_reset(rx_reset), .rx_enable(rx_enable),
    .push_valid(push_valid), .pop(pop), .do_push(do_push), .do_pop(do_pop),
    .wptr(wptr), .rptr(rptr), .empty(empty), .full(full),
    .overrun(overrun), .rd_valid(rd_valid)
  );

  rxf_mem #(.W($bits(entry_t)), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(do_push), .waddr(wptr), .wdata(wr_ent),
    .re(do_pop), .raddr(rptr), .rdata(rd_ent)
  );

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_UART;
    else if (do_pop) mode_q <= mode_e'(mode);
  end

  rxf_align u_align (.mode(mode_q), .ent(rd_ent), .word(rd_data));

  assign irq = rx_enable && !empty;

  // R12
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !irq);

  // R5
  flag_slot_only_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && mode_q != MODE_SLOT) |-> !rd_data[11]);
endmodule

// File: tb/tb_rx_sample_fifo.sv
module tb_rx_sample_fifo;
  logic        clk = 1'b0;
  logic        rst, rx_reset, rx_enable, push_valid, push_wide, push_first, pop;
  logic [1:0]  mode;
  logic [19:0] push_data;
  logic        rd_valid, empty, full, overrun, irq;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rx_sample_fifo dut (
    .clk(clk), .rst(rst), .rx_reset(rx_reset), .rx_enable(rx_enable),
    .mode(mode), .push_valid(push_valid), .push_data(push_data),
    .push_wide(push_wide), .push_first(push_first), .pop(pop),
    .rd_valid(rd_valid), .rd_data(rd_data), .empty(empty), .full(full),
    .overrun(overrun), .irq(irq)
  );

  // {mode[1:0], wide, first, data[19:0], expected word[31:0]}
  localparam int NV = 8;
  localparam logic [55:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 20'h123A5, 32'hA500_0000},  // R1
    {2'b01, 1'b0, 1'b0, 20'h0003C, 32'h3C00_0000},  // R1
    {2'b10, 1'b0, 1'b0, 20'h0BEEF, 32'hBEEF_0000},  // R2
    {2'b11, 1'b1, 1'b0, 20'hABCDE, 32'hABCD_E000},  // R3
    {2'b11, 1'b1, 1'b1, 20'hABCDE, 32'hABCD_E800},  // R3
    {2'b11, 1'b0, 1'b1, 20'h01234, 32'h1234_0800},  // R4
    {2'b11, 1'b0, 1'b0, 20'h05678, 32'h5678_0000},  // R4
    {2'b10, 1'b0, 1'b1, 20'hF1234, 32'h1234_0000}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [19:0] d, input logic w, input logic f);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; push_wide = w; push_first = f;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pull(output logic [31:0] d, output logic v);
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        v;
    rst = 1'b1; rx_reset = 1'b0; rx_enable = 1'b1; push_valid = 1'b0;
    push_wide = 1'b0; push_first = 1'b0; pop = 1'b0; mode = 2'b00; push_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset empty", {31'b0, empty}, 32'd1);
    chk("R7 reset full", {31'b0, full}, 32'd0);
    chk("R8 reset overrun", {31'b0, overrun}, 32'd0);
    chk("R12 reset irq", {31'b0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][55:54];
      push(VEC[i][51:32], VEC[i][53], VEC[i][52]);
      pull(d, v);
      chk("R6 vector valid", {31'b0, v}, 32'd1);
      chk("R1-4 vector word (R1 R2 R3 R4 R5)", d, VEC[i][31:0]);
    end

    // R6 pop on empty
    pull(d, v);
    chk("R6 empty pop valid", {31'b0, v}, 32'd0);
    chk("R6 empty pop empty", {31'b0, empty}, 32'd1);

    // R7 R8 fill, overflow, drain
    mode = 2'b10;
    for (int i = 0; i < 16; i++) push(20'h00100 + 20'(i), 1'b0, 1'b0);
    chk("R7 full", {31'b0, full}, 32'd1);
    chk("R8 no overrun yet", {31'b0, overrun}, 32'd0);
    push(20'h0DEAD, 1'b0, 1'b0);
    chk("R8 overrun set", {31'b0, overrun}, 32'd1);
    for (int i = 0; i < 16; i++) begin
      pull(d, v);
      chk("R6 drain order", d, {16'h0100 + 16'(i), 16'h0});
    end
    chk("R8 dropped sample absent", {31'b0, empty}, 32'd1);
    chk("R8 overrun sticky", {31'b0, overrun}, 32'd1);

    // R12 R9
    push(20'h0A1B2, 1'b0, 1'b0);
    chk("R12 irq on data", {31'b0, irq}, 32'd1);
    @(negedge clk); rx_enable = 1'b0;
    #1;
    chk("R12 irq masked by enable", {31'b0, irq}, 32'd0);
    push(20'h0FFFF, 1'b0, 1'b0);
    pull(d, v);
    chk("R9 read while disabled", d, 32'hA1B2_0000);
    chk("R9 push ignored while disabled", {31'b0, empty}, 32'd1);
    @(negedge clk); rx_enable = 1'b1;

    // R10 reset beats pop
    push(20'h01111, 1'b0, 1'b0);
    @(negedge clk); rx_reset = 1'b1; pop = 1'b1;
    @(negedge clk); rx_reset = 1'b0; pop = 1'b0;
    chk("R10 no valid on reset pop", {31'b0, rd_valid}, 32'd0);
    chk("R10 flushed", {31'b0, empty}, 32'd1);
    chk("R10 overrun cleared", {31'b0, overrun}, 32'd0);
    chk("R10 irq dropped", {31'b0, irq}, 32'd0);

    // R11 disarmed until enable toggles
    push(20'h02222, 1'b0, 1'b0);
    chk("R11 push refused after reset", {31'b0, empty}, 32'd1);
    @(negedge clk); rx_enable = 1'b0;
    @(negedge clk); rx_enable = 1'b1;
    push(20'h03333, 1'b0, 1'b0);
    chk("R11 push accepted after re-enable", {31'b0, empty}, 32'd0);
    pull(d, v);
    chk("R11 accepted data", d, 32'h3333_0000);

    // R8 simultaneous push and pop while full
    for (int i = 0; i < 16; i++) push(20'h00200 + 20'(i), 1'b0, 1'b0);
    @(negedge clk);
    push_valid = 1'b1; push_data = 20'h0BBBB; pop = 1'b1;
    @(negedge clk);
    push_valid = 1'b0; pop = 1'b0;
    chk("R8 collide valid", {31'b0, rd_valid}, 32'd1);
    chk("R8 collide oldest out", rd_data, 32'h0200_0000);
    chk("R8 collide still full", {31'b0, full}, 32'd1);
    chk("R8 collide no overrun", {31'b0, overrun}, 32'd0);
    for (int i = 1; i < 16; i++) pull(d, v);
    pull(d, v);
    chk("R8 collide new sample last", d, 32'hBBBB_0000);
    chk("R7 empty after drain", {31'b0, empty}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule